// File: doc/BRIEF.md
# Multi-Mode Iterative Multiplier

This block multiplies two WIDTH-bit operands (32 by default) over several clock cycles and returns one WIDTH-bit half of the 2·WIDTH-bit product. A two-bit mode selects what is returned. One choice is the low half. The other three are the high half with both operands unsigned, with operand A signed and B unsigned, or with both operands signed. A one-cycle `start` pulse in the idle state captures the operands and the mode. After a fixed, mode-dependent number of cycles, `done` pulses for one cycle and `result` carries the answer. `result` then holds that value until the next completion.

The controller runs one shift-and-add step per cycle, WIDTH steps in all. Each step updates two accumulators at once. The low-half accumulator shifts left and adds A when the current top bit of a left-shifting copy of B is set. The high-half accumulator adds A when the current bottom bit of a right-shifting copy of B is set, then shifts right, and the carry of that add enters the top bit. After the loop, the signed high halves are formed from the unsigned high half. One cycle subtracts the saved original B when A is negative. A second cycle, used only when both operands are signed, subtracts A when the original B is negative. A multiply with a 16-bit immediate is served by low-half mode with the immediate sign-extended into operand B.

Controller states: `ST_IDLE` (waiting), `ST_STEP` (WIDTH iterations), `ST_FIXA` (A-sign correction), `ST_FIXB` (B-sign correction) and `ST_DONE` (done pulse). The transitions are as follows.
- `ST_IDLE`→`ST_STEP` on `start`.
- `ST_STEP`→`ST_STEP` until the last step.
- After the last step, `ST_STEP` goes to `ST_FIXA` for the two signed modes and to `ST_DONE` otherwise.
- `ST_FIXA`→`ST_FIXB` for the signed×signed mode and →`ST_DONE` otherwise.
- `ST_FIXB`→`ST_DONE`.
- `ST_DONE`→`ST_IDLE`.

Top module: `iter_mul_unit`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `result` is 0.
- R2: Mode 2'b00 returns the low WIDTH bits of A×B. The same bits result whether the operands are read as signed or unsigned.
- R3: Mode 2'b01 returns the high WIDTH bits of the product, with A and B both read as unsigned.
- R4: Mode 2'b10 returns the high WIDTH bits of the product, with A read as two's-complement signed and B as unsigned.
- R5: Mode 2'b11 returns the high WIDTH bits of the product, with A and B both read as two's-complement signed.
- R6: Let E be the clock edge that samples an accepted `start`. `done` is high in the cycle that follows edge E+L. L is WIDTH for modes 00 and 01, WIDTH+1 for mode 10, and WIDTH+2 for mode 11.
- R7: `done` is high for exactly one cycle per accepted operation.
- R8: `start` is accepted only in the idle state. A `start` while an operation is in progress (or in its done cycle) has no effect: the running operation's result and latency are unchanged, and no extra `done` follows.
- R9: `result` changes only in a cycle where `done` is high. Between completions, including while a new operation is running, it holds the last result.
- R10: A multiply by a 16-bit immediate, run in mode 00 with the immediate sign-extended to WIDTH bits as B, returns the low WIDTH bits of A times the signed immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | 00 low, 01 high u×u, 10 high s×u, 11 high s×s |
| op_a | input | WIDTH | Operand A (multiplicand) |
| op_b | input | WIDTH | Operand B (multiplier) |
| result | output | WIDTH | Selected product half, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the checker verifies the following against its own wide reference product of the captured operands:
- each completed result, in all four modes;
- the mode-dependent latency, measured with its own counter;
- that `done` is a single-cycle pulse that never appears without an accepted start;
- that `result` never moves outside a `done` cycle.

Only the bench scenarios show three further behaviours:
- that a start issued mid-operation is truly discarded, because the bench loads different operands with it and later sees the original answer;
- the operand corners 0, 1, −1, the most negative value and the most positive value in every mode pairing;
- the sign-extended immediate case, and the reset values.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

    typedef enum logic [1:0] {
        MD_LOW   = 2'b00,
        MD_HI_UU = 2'b01,
        MD_HI_SU = 2'b10,
        MD_HI_SS = 2'b11
    } mul_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_STEP = 3'd1,
        ST_FIXA = 3'd2,
        ST_FIXB = 3'd3,
        ST_DONE = 3'd4
    } mul_state_e;

endpackage

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl
    import iter_mul_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] mode_q,
    output logic       idle,
    output logic       load,
    output logic       step,
    output logic       fix_a,
    output logic       fix_b,
    output logic       fin,
    output logic       done
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    mul_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    mul_mode_e  mode_e;

    assign mode_e = mul_mode_e'(mode_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (state_q == ST_IDLE)         cnt_q <= '0;
        else if (state_q == ST_STEP)         cnt_q <= cnt_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_STEP;
            ST_STEP: begin
                if (cnt_q == LAST) begin
                    if (mode_e == MD_HI_SU || mode_e == MD_HI_SS) state_d = ST_FIXA;
                    else                                          state_d = ST_DONE;
                end
            end
            ST_FIXA: state_d = (mode_e == MD_HI_SS) ? ST_FIXB : ST_DONE;
            ST_FIXB: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle  = 1'b0;
        load  = 1'b0;
        step  = 1'b0;
        fix_a = 1'b0;
        fix_b = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle = 1'b1;
                load = start;
            end
            ST_STEP: step  = 1'b1;
            ST_FIXA: fix_a = 1'b1;
            ST_FIXB: fix_b = 1'b1;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
        fin = (state_d == ST_DONE) && (state_q != ST_DONE);
    end

endmodule

// File: rtl/iter_mul_opreg.sv
module iter_mul_opreg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [1:0]       mode_q,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_orig_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            a_q      <= '0;
            b_orig_q <= '0;
        end else if (load) begin
            mode_q   <= mode;
            a_q      <= op_a;
            b_orig_q <= op_b;
        end
    end

endmodule

// File: rtl/iter_mul_lohalf.sv
module iter_mul_lohalf #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] lo_next
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] mpl_q;
    logic [WIDTH-1:0] addend;

    // add the multiplicand when the top bit of the left-moving multiplier is set
    assign addend  = mpl_q[WIDTH-1] ? a_q : '0;
    assign lo_next = step ? ((acc_q << 1) + addend) : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            mpl_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            mpl_q <= op_b;
        end else if (step) begin
            acc_q <= lo_next;
            mpl_q <= mpl_q << 1;
        end
    end

endmodule

// File: rtl/iter_mul_hihalf.sv
module iter_mul_hihalf #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             fix_a,
    input  logic             fix_b,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] a_q,
    input  logic [WIDTH-1:0] b_orig_q,
    output logic [WIDTH-1:0] hi_next
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] mpr_q;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] halved_sum;
    logic [WIDTH-1:0] sub_val;

    assign addend = mpr_q[0] ? a_q : '0;

    // (acc + addend) >> 1 with the carry-out landing in the top bit
    assign halved_sum = {1'b0, acc_q[WIDTH-1:1]} + {1'b0, addend[WIDTH-1:1]}
                      + WIDTH'(acc_q[0] & addend[0]);

    // sign corrections: subtract B if A negative, then A if original B negative
    always_comb begin
        sub_val = '0;
        if (fix_a && a_q[WIDTH-1])      sub_val = b_orig_q;
        if (fix_b && b_orig_q[WIDTH-1]) sub_val = a_q;
    end

    always_comb begin
        if (step)               hi_next = halved_sum;
        else if (fix_a | fix_b) hi_next = acc_q - sub_val;
        else                    hi_next = acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            mpr_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            mpr_q <= op_b;
        end else begin
            acc_q <= hi_next;
            if (step) mpr_q <= mpr_q >> 1;
        end
    end

endmodule

// File: rtl/iter_mul_unit.sv
module iter_mul_unit
    import iter_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    logic             idle_w, load_w, step_w, fixa_w, fixb_w, fin_w;
    logic [1:0]       mode_q;
    logic [WIDTH-1:0] a_q, b_orig_q;
    logic [WIDTH-1:0] lo_next, hi_next;
    logic [WIDTH-1:0] res_q;

    iter_mul_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode_q (mode_q),
        .idle   (idle_w),
        .load   (load_w),
        .step   (step_w),
        .fix_a  (fixa_w),
        .fix_b  (fixb_w),
        .fin    (fin_w),
        .done   (done)
    );

    iter_mul_opreg #(.WIDTH(WIDTH)) u_opreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .mode     (mode),
        .op_a     (op_a),
        .op_b     (op_b),
        .mode_q   (mode_q),
        .a_q      (a_q),
        .b_orig_q (b_orig_q)
    );

    iter_mul_lohalf #(.WIDTH(WIDTH)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .step    (step_w),
        .op_b    (op_b),
        .a_q     (a_q),
        .lo_next (lo_next)
    );

    iter_mul_hihalf #(.WIDTH(WIDTH)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .step     (step_w),
        .fix_a    (fixa_w),
        .fix_b    (fixb_w),
        .op_b     (op_b),
        .a_q      (a_q),
        .b_orig_q (b_orig_q),
        .hi_next  (hi_next)
    );

    // result register, loaded on the edge that enters the done state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     res_q <= '0;
        else if (fin_w) res_q <= (mul_mode_e'(mode_q) == MD_LOW) ? lo_next : hi_next;
    end

    assign result = res_q;

endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] result,
    input logic             done,
    input logic             idle
);

    logic [WIDTH-1:0]   ca, cb;
    logic [1:0]         cm;
    logic               pend;
    int unsigned        lat_cnt;
    int unsigned        exp_lat;
    logic [2*WIDTH-1:0] xa, xb, prod;
    logic [WIDTH-1:0]   exp_res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca <= '0; cb <= '0; cm <= '0; pend <= 1'b0; lat_cnt <= 0;
        end else if (start && idle) begin
            ca <= op_a; cb <= op_b; cm <= mode; pend <= 1'b1; lat_cnt <= 0;
        end else begin
            if (pend) lat_cnt <= lat_cnt + 1;
            if (done) pend <= 1'b0;
        end
    end

    always_comb begin
        xa = (cm[1]) ? {{WIDTH{ca[WIDTH-1]}}, ca} : {{WIDTH{1'b0}}, ca};
        xb = (cm == 2'b11) ? {{WIDTH{cb[WIDTH-1]}}, cb} : {{WIDTH{1'b0}}, cb};
        prod = xa * xb;
        exp_res = (cm == 2'b00) ? prod[WIDTH-1:0] : prod[2*WIDTH-1:WIDTH];
        exp_lat = WIDTH + ((cm == 2'b10) ? 1 : 0) + ((cm == 2'b11) ? 2 : 0);
    end

    p_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cm == 2'b00) |-> (result == exp_res));
    p_high_uu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cm == 2'b01) |-> (result == exp_res));
    p_high_su_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cm == 2'b10) |-> (result == exp_res));
    p_high_ss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cm == 2'b11) |-> (result == exp_res));
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == exp_lat));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pend);
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind iter_mul_unit iter_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .done   (done),
    .idle   (idle_w)
);

// File: tb/iter_mul_unit_test.sv
module iter_mul_unit_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         done;

    always #5 clk = ~clk;

    iter_mul_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .result(result), .done(done)
    );

    typedef struct {
        logic [W-1:0] res;
        int           lat;
        int           t0;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           cyc = 0;
    int           n_tests = 0;
    int           n_fail = 0;
    logic [W-1:0] last_res = '0;
    logic         prev_done = 1'b0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [1:0] m);
        logic [2*W-1:0] ea, eb, p;
        ea = (m == 2'b10 || m == 2'b11) ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = (m == 2'b11) ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        p = ea * eb;
        return (m == 2'b00) ? p[W-1:0] : p[2*W-1:W];
    endfunction

    function automatic int ref_lat(input logic [1:0] m);
        return (m == 2'b10) ? W + 1 : (m == 2'b11) ? W + 2 : W;
    endfunction

    function automatic string mtag(input logic [1:0] m);
        case (m)
            2'b00:   return "R2 low half";
            2'b01:   return "R3 high uu";
            2'b10:   return "R4 high su";
            default: return "R5 high ss";
        endcase
    endfunction

    // cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R6 actual=hung expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // monitor: pop expected items as results appear
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (done) begin
                chk_int("R7 done pulse width", int'(prev_done), 0);
                if (sb.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R8 unexpected done actual=%h expected=no done", result);
                end else begin
                    e = sb.pop_front();
                    chk(e.tag, result, e.res);
                    chk_int({e.tag, " R6 latency"}, cyc - e.t0, e.lat);
                    last_res = result;
                end
            end
            prev_done = done;
        end
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [1:0] m, input string tag);
        exp_t e;
        drain();
        e.res = ref_res(a, b, m);
        e.lat = ref_lat(m);
        e.t0  = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
        op_a  = a;
        op_b  = b;
        mode  = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        logic [W-1:0] cv [5];
        logic [15:0]  imm;
        logic [W-1:0] held;
        cv[0] = 32'h0000_0000;
        cv[1] = 32'h0000_0001;
        cv[2] = 32'hFFFF_FFFF;
        cv[3] = 32'h8000_0000;
        cv[4] = 32'h7FFF_FFFF;

        repeat (3) @(negedge clk);
        chk("R1 reset done", W'(done), '0);
        chk("R1 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // corner operands in every mode
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int m = 0; m < 4; m++)
                    run_op(cv[i], cv[j], 2'(m), mtag(2'(m)));

        // mixed operands
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            run_op(ra, rb, 2'(k % 4), mtag(2'(k % 4)));
        end

        // immediate form: sign-extended 16-bit operand in low-half mode
        imm = 16'hFF85;
        run_op(32'd1000, {{16{imm[15]}}, imm}, 2'b00, "R10 negative immediate");
        imm = 16'h7FFF;
        run_op(32'hDEAD_BEEF, {{16{imm[15]}}, imm}, 2'b00, "R10 positive immediate");

        // start while busy must be ignored
        run_op(32'h8000_0001, 32'hFFFF_FFF3, 2'b11, "R8 busy start keeps ss result");
        repeat (5) @(negedge clk);
        op_a  = 32'h1234_5678;
        op_b  = 32'h0000_0002;
        mode  = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();

        // result held while idle and while a new operation is running
        repeat (40) @(negedge clk);
        chk("R9 result held while idle", result, last_res);
        held = last_res;
        run_op(32'h0000_0003, 32'h0000_0005, 2'b01, "R3 high uu small");
        repeat (10) @(negedge clk);
        chk("R9 result held mid-operation", result, held);
        drain();

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule